// File: doc/BRIEF.md
# Programmable AND-Term Sequencing Macrocell

This block is one configurable logic cell of a power-sequencing fabric. It watches 21 status inputs: eight outputs of peer cells, seven supply fault flags, four general-purpose inputs, and a pulsed and a latched watchdog flag. It turns them into a single output. Each input can be inverted and can be forced to a logical 1 ("ignored") separately for each of two product terms, A and B. The enabled terms are ORed into one condition. A programmable rise-time delay then holds back the assertion of that condition, and an output polarity bit is applied last.

Typical use: invert every supply fault flag so that each reads "supply good", ignore everything else, enable term A and program a delay. The output then rises a set number of timer ticks after all supplies are good, for example to enable a regulator. Configuration is held in a bank of byte registers written through a simple write port. All registers are zero after reset. A cell's own output is never among its peer inputs.

Top module: `seq_macrocell`

## Requirements
- R1: After reset every configuration register is zero, both terms are disabled, and `cellOut` is 0.
- R2: When an input's ignore bit is 1 for a term, that input contributes a constant 1 to that term, whatever its level.
- R3: When an input's invert bit is 1 for a term, the complement of the input enters that term's AND. Otherwise the input enters unchanged.
- R4: A term whose enable bit is 0 contributes 0. The combined condition is the OR of the enabled terms.
- R5: Control register bit 2 set to 1 inverts `cellOut` relative to the delayed condition.
- R6: While the combined condition stays 1, the counter advances on each cycle with `tick` high until it equals the delay register value. The delayed condition becomes 1 at the next clock edge, so a delay of 0 asserts one cycle after the condition rises.
- R7: When the combined condition is 0, the delayed condition is 0 in that same cycle (no clock edge needed) and the tick count restarts from zero.
- R8: Byte offsets (write address): 0x0/0x8 peer invert A/B, 0x1/0x9 peer ignore A/B, 0x2/0xA fault invert A/B (bits 6:0), 0x3/0xB fault ignore A/B, 0x4/0x5 general-purpose config A/B (bits 3:0 invert, bits 7:4 ignore), 0x6 watchdog config shared by both terms (bit0 pulsed invert, bit1 pulsed ignore, bit2 latched invert, bit3 latched ignore), 0x7 control (bit0 enable A, bit1 enable B, bit2 output polarity), 0xC delay terminal count. A write takes effect from the next cycle.
- R9: Writes to offsets 0xD, 0xE and 0xF change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| peerIn | input | 8 | Outputs of the eight peer cells |
| faultIn | input | 7 | Supply fault flags, 1 = fault |
| gpIn | input | 4 | General-purpose inputs |
| wdPulse | input | 1 | Pulsed watchdog flag |
| wdLatch | input | 1 | Latched watchdog flag |
| tick | input | 1 | Time base strobe for the rise delay |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register byte offset |
| wrData | input | 8 | Register write data |
| cellOut | output | 1 | Delayed, polarity-adjusted cell output |

## Verification
A register write becomes visible one cycle after its strobe. Input changes reach `cellOut` in the same cycle when they drop the condition or when the delayed state is already set. A rising condition shows up only after the edge at which the count reaches its terminal value, one cycle after the condition rises for a zero delay. The bench drives inputs just after a rising edge and compares the output against a behavioural model one time unit later, still in the same cycle. It then advances the model's state as the edge will. Every cycle is compared, so the same-cycle drop and the one-edge-late rise are both checked at their exact cycle.

// File: rtl/seqmc_pkg.sv
package seqmc_pkg;
  localparam int PEER_N  = 8;
  localparam int FAULT_N = 7;
  localparam int GP_N    = 4;
  localparam int WD_N    = 2;
  localparam int TERM_N  = 2;
  localparam int CNT_W   = 8;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;

  // byte offsets; term B copies sit at offset + TERM_B_STEP
  localparam logic [ADDR_W-1:0] OFF_PEER_INV  = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_PEER_IGN  = 4'h1;
  localparam logic [ADDR_W-1:0] OFF_FAULT_INV = 4'h2;
  localparam logic [ADDR_W-1:0] OFF_FAULT_IGN = 4'h3;
  localparam logic [ADDR_W-1:0] OFF_GP_A      = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_GP_B      = 4'h5;
  localparam logic [ADDR_W-1:0] OFF_WD        = 4'h6;
  localparam logic [ADDR_W-1:0] OFF_CTRL      = 4'h7;
  localparam logic [ADDR_W-1:0] OFF_LIMIT     = 4'hC;
  localparam logic [ADDR_W-1:0] TERM_B_STEP   = 4'h8;

  typedef struct packed {
    logic [TERM_N-1:0][PEER_N-1:0]  peerInv;
    logic [TERM_N-1:0][PEER_N-1:0]  peerIgn;
    logic [TERM_N-1:0][FAULT_N-1:0] faultInv;
    logic [TERM_N-1:0][FAULT_N-1:0] faultIgn;
    logic [TERM_N-1:0][GP_N-1:0]    gpInv;
    logic [TERM_N-1:0][GP_N-1:0]    gpIgn;
    logic [WD_N-1:0]                wdInv;   // [0] pulsed, [1] latched
    logic [WD_N-1:0]                wdIgn;
    logic [TERM_N-1:0]              termEn;
    logic                           outPol;
    logic [CNT_W-1:0]               limit;
  } cellCfg_t;

  typedef struct packed {
    logic clear;
    logic inc;
    logic set;
  } seqStrobe_t;
endpackage

// File: rtl/seqmc_cfg_regs.sv
module seqmc_cfg_regs
  import seqmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output cellCfg_t          cfg
);
  cellCfg_t cfgQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        OFF_PEER_INV:                 cfgQ.peerInv[0]  <= wrData[PEER_N-1:0];
        OFF_PEER_IGN:                 cfgQ.peerIgn[0]  <= wrData[PEER_N-1:0];
        OFF_FAULT_INV:                cfgQ.faultInv[0] <= wrData[FAULT_N-1:0];
        OFF_FAULT_IGN:                cfgQ.faultIgn[0] <= wrData[FAULT_N-1:0];
        OFF_PEER_INV + TERM_B_STEP:   cfgQ.peerInv[1]  <= wrData[PEER_N-1:0];
        OFF_PEER_IGN + TERM_B_STEP:   cfgQ.peerIgn[1]  <= wrData[PEER_N-1:0];
        OFF_FAULT_INV + TERM_B_STEP:  cfgQ.faultInv[1] <= wrData[FAULT_N-1:0];
        OFF_FAULT_IGN + TERM_B_STEP:  cfgQ.faultIgn[1] <= wrData[FAULT_N-1:0];
        OFF_GP_A: begin
          cfgQ.gpInv[0] <= wrData[GP_N-1:0];
          cfgQ.gpIgn[0] <= wrData[2*GP_N-1:GP_N];
        end
        OFF_GP_B: begin
          cfgQ.gpInv[1] <= wrData[GP_N-1:0];
          cfgQ.gpIgn[1] <= wrData[2*GP_N-1:GP_N];
        end
        OFF_WD: begin
          cfgQ.wdInv <= {wrData[2], wrData[0]};
          cfgQ.wdIgn <= {wrData[3], wrData[1]};
        end
        OFF_CTRL: begin
          cfgQ.termEn <= wrData[TERM_N-1:0];
          cfgQ.outPol <= wrData[2];
        end
        OFF_LIMIT: cfgQ.limit <= wrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign cfg = cfgQ;

  a_r8_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == OFF_CTRL) |=> (cfg.termEn == $past(wrData[1:0]) && cfg.outPol == $past(wrData[2])));
  a_r9_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr > OFF_LIMIT) |=> $stable(cfg));
endmodule

// File: rtl/seqmc_ctrl.sv
module seqmc_ctrl
  import seqmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cond,
  input  logic       held,
  input  logic       atLimit,
  input  logic       tick,
  output seqStrobe_t strobe
);
  always_comb begin
    strobe       = '0;
    strobe.clear = !cond;
    if (cond && !held) begin
      strobe.set = atLimit;
      strobe.inc = !atLimit && tick;
    end
  end

  a_r6_rise_at_limit: assert property (@(posedge clk) disable iff (rst)
    (cond && !held && atLimit) |=> held);
  a_r7_held_needs_cond: assert property (@(posedge clk) disable iff (rst)
    (held && !cond) |=> !held);
endmodule

// File: rtl/seqmc_datapath.sv
module seqmc_datapath
  import seqmc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  cellCfg_t           cfg,
  input  logic [PEER_N-1:0]  peerIn,
  input  logic [FAULT_N-1:0] faultIn,
  input  logic [GP_N-1:0]    gpIn,
  input  logic               wdPulse,
  input  logic               wdLatch,
  input  seqStrobe_t         strobe,
  output logic               cond,
  output logic               held,
  output logic               atLimit,
  output logic               cellOut
);
  logic [TERM_N-1:0] termHit;
  logic [CNT_W-1:0]  cnt;
  logic [WD_N-1:0]   wdVec;

  assign wdVec = {wdLatch, wdPulse};

  for (genvar t = 0; t < TERM_N; t++) begin : g_term
    logic [PEER_N-1:0]  peerOk;
    logic [FAULT_N-1:0] faultOk;
    logic [GP_N-1:0]    gpOk;
    logic [WD_N-1:0]    wdOk;
    assign peerOk  = (peerIn  ^ cfg.peerInv[t])  | cfg.peerIgn[t];
    assign faultOk = (faultIn ^ cfg.faultInv[t]) | cfg.faultIgn[t];
    assign gpOk    = (gpIn    ^ cfg.gpInv[t])    | cfg.gpIgn[t];
    assign wdOk    = (wdVec   ^ cfg.wdInv)       | cfg.wdIgn;
    assign termHit[t] = cfg.termEn[t] & (&peerOk) & (&faultOk) & (&gpOk) & (&wdOk);
  end

  assign cond    = |termHit;
  assign atLimit = (cnt >= cfg.limit);

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      cnt  <= '0;
      held <= 1'b0;
    end else begin
      if (strobe.inc) cnt  <= cnt + 1'b1;
      if (strobe.set) held <= 1'b1;
    end
  end

  assign cellOut = (held & cond) ^ cfg.outPol;

  a_r7_drop_restarts: assert property (@(posedge clk) disable iff (rst)
    !cond |=> (cnt == '0 && !held));
  a_r6_rise_needs_cond: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> $past(cond));
  a_r4_disabled_silent: assert property (@(posedge clk) disable iff (rst)
    (cfg.termEn == '0) |-> !cond);
endmodule

// File: rtl/seq_macrocell.sv
module seq_macrocell
  import seqmc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [PEER_N-1:0]  peerIn,
  input  logic [FAULT_N-1:0] faultIn,
  input  logic [GP_N-1:0]    gpIn,
  input  logic               wdPulse,
  input  logic               wdLatch,
  input  logic               tick,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  output logic               cellOut
);
  cellCfg_t   cfg;
  seqStrobe_t strobe;
  logic       cond, held, atLimit;

  seqmc_cfg_regs u_regs (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .cfg(cfg)
  );

  seqmc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cond(cond), .held(held), .atLimit(atLimit),
    .tick(tick), .strobe(strobe)
  );

  seqmc_datapath u_dp (
    .clk(clk), .rst(rst), .cfg(cfg), .peerIn(peerIn), .faultIn(faultIn),
    .gpIn(gpIn), .wdPulse(wdPulse), .wdLatch(wdLatch), .strobe(strobe),
    .cond(cond), .held(held), .atLimit(atLimit), .cellOut(cellOut)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !cellOut);
endmodule

// File: tb/tb_seq_macrocell.sv
`timescale 1ns/1ps
module tb_seq_macrocell;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] peerIn;
  logic [6:0] faultIn;
  logic [3:0] gpIn;
  logic       wdPulse, wdLatch, tick, wrEn;
  logic [3:0] wrAddr;
  logic [7:0] wrData;
  logic       cellOut;

  int testsRun = 0;
  int testsFailed = 0;
  string curReq = "R1";

  // behavioural reference state
  logic [7:0] mreg [16];
  int         mcnt;
  bit         mheld;

  always #2.5 clk = ~clk;

  seq_macrocell dut (
    .clk(clk), .rst(rst), .peerIn(peerIn), .faultIn(faultIn), .gpIn(gpIn),
    .wdPulse(wdPulse), .wdLatch(wdLatch), .tick(tick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .cellOut(cellOut)
  );

  function automatic bit termVal(int t);
    int  base = (t == 0) ? 0 : 8;
    bit  v = mreg[7][t];
    bit  wd [2];
    wd[0] = wdPulse;
    wd[1] = wdLatch;
    for (int i = 0; i < 8; i++)
      if (!mreg[base+1][i] && (peerIn[i] == mreg[base+0][i])) v = 0;
    for (int i = 0; i < 7; i++)
      if (!mreg[base+3][i] && (faultIn[i] == mreg[base+2][i])) v = 0;
    for (int i = 0; i < 4; i++)
      if (!mreg[4+t][4+i] && (gpIn[i] == mreg[4+t][i])) v = 0;
    for (int i = 0; i < 2; i++)
      if (!mreg[6][2*i+1] && (wd[i] == mreg[6][2*i])) v = 0;
    return v;
  endfunction

  task automatic cyc();
    bit c, exp;
    #1;
    c   = termVal(0) | termVal(1);
    exp = (mheld & c) ^ mreg[7][2];
    testsRun++;
    if (cellOut !== exp) begin
      testsFailed++;
      $display("FAIL %s: cellOut=%0b expected=%0b at %0t", curReq, cellOut, exp, $time);
    end
    // advance model as the coming edge will
    if (!c) begin
      mcnt  = 0;
      mheld = 0;
    end else if (!mheld) begin
      if (mcnt >= int'(mreg[12])) mheld = 1;
      else if (tick) mcnt++;
    end
    if (wrEn && (wrAddr <= 4'hC)) mreg[wrAddr] = wrData;
    @(posedge clk);
    #0.5;
    wrEn = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    cyc();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(200000 * 5);
    testsFailed++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rst = 1'b1; peerIn = '0; faultIn = '0; gpIn = '0; wdPulse = 0; wdLatch = 0;
    tick = 1'b1; wrEn = 0; wrAddr = '0; wrData = '0;
    foreach (mreg[i]) mreg[i] = '0;
    mcnt = 0; mheld = 0;
    repeat (3) @(posedge clk);
    #0.5 rst = 1'b0;

    // R1: reset state, all-ones inputs still give 0 (terms disabled)
    curReq = "R1";
    peerIn = '1; faultIn = '1; gpIn = '1; wdPulse = 1; wdLatch = 1;
    idle(3);

    // R2/R8: ignore everything on term A, enable A, delay 0
    curReq = "R2";
    wr(4'h1, 8'hFF); wr(4'h3, 8'h7F); wr(4'h4, 8'hF0); wr(4'h6, 8'h0A);
    peerIn = '0; faultIn = 7'h55; gpIn = 4'h0;
    wr(4'h7, 8'h01);
    idle(3);

    // R3: faults as supply-good via invert
    curReq = "R3";
    wr(4'h3, 8'h00); wr(4'h2, 8'h7F);
    faultIn = '0; idle(3);
    faultIn = 7'h08; idle(2);   // R7: same-cycle drop
    curReq = "R7";
    faultIn = '0; idle(2);
    curReq = "R3";
    wr(4'h4, 8'h00); gpIn = 4'hF; idle(2);
    gpIn = 4'hB; idle(2);
    wr(4'h4, 8'h04); idle(2);   // invert gp bit 2
    wr(4'h0, 8'hA5); wr(4'h1, 8'h00); peerIn = 8'h5A; idle(2);
    peerIn = 8'h5B; idle(2);
    wr(4'h6, 8'h05); wdPulse = 0; wdLatch = 0; idle(2);
    wdLatch = 1; idle(2);

    // R6/R7: delay with sparse ticks and restart
    curReq = "R6";
    wr(4'h6, 8'h0A); wr(4'h1, 8'hFF); wr(4'h4, 8'hF0);
    wr(4'hC, 8'd5);
    faultIn = 7'h01; idle(2);
    faultIn = '0;
    for (int i = 0; i < 16; i++) begin tick = i[0]; cyc(); end
    curReq = "R7";
    faultIn = 7'h40; idle(1);
    faultIn = '0;
    for (int i = 0; i < 6; i++) begin tick = i[0]; cyc(); end
    faultIn = 7'h02; idle(1); faultIn = '0;
    tick = 1'b1; idle(8);
    wr(4'hC, 8'd0);

    // R4: term B alone, both, neither
    curReq = "R4";
    wr(4'h9, 8'hFF); wr(4'hB, 8'h7F); wr(4'h5, 8'hF0);
    wr(4'h7, 8'h02); idle(3);
    faultIn = 7'h10; idle(2);   // A would fail, B ignores
    wr(4'h7, 8'h03); idle(2);
    wr(4'h7, 8'h00); idle(2);

    // R5: output polarity
    curReq = "R5";
    wr(4'h7, 8'h04); idle(2);
    wr(4'h7, 8'h06); idle(3);

    // R9: unmapped offsets leave control untouched
    curReq = "R9";
    wr(4'h7, 8'h00);
    wr(4'hF, 8'hFF); wr(4'hE, 8'hFF); wr(4'hD, 8'hFF); idle(3);

    // mixed random traffic, all requirements via model (R8)
    curReq = "R8";
    for (int i = 0; i < 400; i++) begin
      peerIn = 8'($urandom); faultIn = 7'($urandom); gpIn = 4'($urandom);
      wdPulse = 1'($urandom); wdLatch = 1'($urandom); tick = 1'($urandom);
      if (($urandom % 4) == 0) wr(4'($urandom), 8'($urandom | 32'hF0));
      else cyc();
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule